// File: doc/BRIEF.md
# Orbit-Aligned Dual-Clock Channel FIFO

This block is one channel's alignment stage in a trigger data path. Every bunch crossing it receives a 9-bit word in the transmit clock domain. Bits [7:0] carry a transverse energy value and bit [8] carries a fine-grain flag; the block passes all nine bits through unchanged. It moves these words into a receive clock domain that every channel shares. Storage is a 128-entry dual-clock FIFO. Its read and write pointers cross between the two domains as gray codes through two-flop synchronizers.

Writing does not start on a free-running handshake. A transmit orbit marker starts it, and that marker can be postponed by a programmable number of crossings so that this channel lines up with the others. Reading starts on a receive orbit marker that all channels see in the same cycle. A write-side crossing counter runs from the delayed marker. Once it reaches a programmable gap position, or the last position of a 3564-crossing orbit, writing stops and a flush request crosses to the read side. The flush discards whatever is left in the FIFO and stops reading until the next receive marker.

A channel enable turns the channel off. A disabled channel outputs zeros and never raises an error. A sticky error flag reports a write into a full FIFO or a read from an empty one.

Top module: `orbit_sync_fifo`

## Requirements
- R1: After reset, data_o is 0, err_o is 0, empty_o is 1 and full_o is 0.
- R2: With delay_i = 0, the first word written is the one on data_i in the transmit cycle where wr_orbit_i is high, and later words follow in arrival order.
- R3: With delay_i = d > 0, the first word written is the one presented d transmit cycles after the cycle where wr_orbit_i is high.
- R4: The first stored word appears on data_o two receive-clock edges after the edge that samples rd_orbit_i high. After that, one stored word appears per receive cycle.
- R5: Writing covers gap_i words, counted from the delayed marker (gap_i >= 1). After that the FIFO contents are flushed and reading stops. Until the next markers, data_o stays 0 and empty_o is 1.
- R6: After a flush, a new pair of markers starts a fresh orbit. Its first output word is the first word written in that orbit.
- R7: Once DEPTH unread words are stored, full_o is 1. Writes attempted while full are dropped, so the stored words are read out unchanged and in order.
- R8: A write attempted while full sets err_o, and err_o stays set until reset.
- R9: A read attempted while empty, after rd_orbit_i has enabled reading, sets err_o until reset. That read produces 0 on data_o.
- R10: With en_i = 0, nothing is written, data_o stays 0, err_o stays 0 and empty_o stays 1.
- R11: A normally aligned orbit, where reading starts after writing and ends at the flush, never sets err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Transmit (write) clock, one cycle per crossing |
| rclk_i | input | 1 | Receive (read) clock, shared by all channels |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| en_i | input | 1 | Channel enable, held static during operation |
| wr_orbit_i | input | 1 | Transmit orbit marker, one-cycle pulse in wclk_i |
| delay_i | input | DLY_W | Marker delay in crossings |
| gap_i | input | CNT_W | Number of words written per orbit before the gap flush |
| data_i | input | 9 | Trigger word: [7:0] energy, [8] fine-grain flag |
| full_o | output | 1 | FIFO full, in the wclk_i domain |
| rd_orbit_i | input | 1 | Receive orbit marker, one-cycle pulse in rclk_i |
| data_o | output | 9 | Re-timed trigger word, 0 when not reading |
| empty_o | output | 1 | FIFO empty, in the rclk_i domain |
| err_o | output | 1 | Sticky overflow/underflow error, rclk_i domain |

## Verification
The bound checker checks on every cycle that the stored level never exceeds the depth and that a write refused while full leaves the write pointer unchanged. It also checks that a flush leaves the FIFO empty, that an empty read yields a zero word, that the error flag stays set, and that a disabled channel stays silent. Other properties need the bench's scenarios to show them: which word becomes first for a given marker delay, the exact two-cycle read latency, the in-order stream across the clock crossing, and the realignment after each flush. The bench builds these from seeded random data, delays and gap lengths, and adds directed overflow, underflow and disabled-channel runs.

// File: rtl/orbit_sync_pkg.sv
package orbit_sync_pkg;
  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/osf_sync.sv
module osf_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/osf_mem.sv
module osf_mem
  import orbit_sync_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output word_t         rdata_o
);
  localparam int unsigned N = 1 << AW;

  word_t mem_q [N];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/osf_wr_ctrl.sv
module osf_wr_ctrl #(
  parameter int unsigned AW        = 7,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned DLY_W     = 6,
  parameter int unsigned ORBIT_LEN = 3564
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             orbit_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [AW:0]      rgray_q_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [AW:0]      wgray_o,
  output logic [AW:0]      wbin_o,
  output logic [AW:0]      level_o,
  output logic             wr_req_o,
  output logic             full_o,
  output logic             err_o,
  output logic             clr_tgl_o
);
  localparam logic [AW:0]      DEPTH_L = (AW+1)'(1) << AW;
  localparam logic [CNT_W-1:0] POS_MAX = CNT_W'(ORBIT_LEN - 1);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DLY_W-1:0] dly_cnt_q;
  logic             dly_busy_q;
  logic             dmark;
  logic             run_q;
  logic [CNT_W-1:0] pos_q;
  logic             gap_hit;
  logic [AW:0]      wbin_q, wgray_q, wbin_nxt;
  logic             err_q, tgl_q;

  // delayed orbit marker
  assign dmark = en_i && ((orbit_i && delay_i == '0) ||
                          (dly_busy_q && dly_cnt_q == DLY_W'(1)));

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_busy_q <= 1'b0;
      dly_cnt_q  <= '0;
    end else if (!en_i) begin
      dly_busy_q <= 1'b0;
    end else if (orbit_i && delay_i != '0) begin
      dly_busy_q <= 1'b1;
      dly_cnt_q  <= delay_i;
    end else if (dly_busy_q) begin
      dly_cnt_q <= dly_cnt_q - DLY_W'(1);
      if (dly_cnt_q == DLY_W'(1)) dly_busy_q <= 1'b0;
    end
  end

  // crossing counter and gap detection
  assign gap_hit  = run_q && (pos_q == gap_i || pos_q == POS_MAX);
  assign wr_req_o = en_i && (dmark || (run_q && !gap_hit));

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pos_q <= '0;
      tgl_q <= 1'b0;
    end else if (!en_i) begin
      run_q <= 1'b0;
    end else if (dmark) begin
      run_q <= 1'b1;
      pos_q <= CNT_W'(1);
    end else if (gap_hit) begin
      run_q <= 1'b0;
      tgl_q <= ~tgl_q;
    end else if (run_q) begin
      pos_q <= pos_q + CNT_W'(1);
    end
  end

  assign level_o = wbin_q - g2b(rgray_q_i);
  assign full_o  = (level_o == DEPTH_L);
  assign we_o    = wr_req_o && !full_o;
  assign wbin_nxt = wbin_q + (AW+1)'(we_o);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      err_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      if (wr_req_o && full_o) err_q <= 1'b1;
    end
  end

  assign waddr_o   = wbin_q[AW-1:0];
  assign wgray_o   = wgray_q;
  assign wbin_o    = wbin_q;
  assign err_o     = err_q;
  assign clr_tgl_o = tgl_q;
endmodule

// File: rtl/osf_rd_ctrl.sv
module osf_rd_ctrl
  import orbit_sync_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          orbit_i,
  input  logic [AW:0]   wgray_q_i,
  input  logic          clr_tgl_i,
  input  logic          werr_i,
  input  word_t         rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_o,
  output word_t         data_o,
  output logic          err_o,
  output logic          rd_fire_o,
  output logic          flush_o
);
  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic        clr_s, clr_d_q, werr_s;
  logic [AW:0] wq_bin, rbin_q, rgray_q, rbin_nxt;
  logic        run_q, rerr_q;
  word_t       stg_q, out_q;

  osf_sync #(.W(1)) i_clr_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(clr_tgl_i), .q_o(clr_s)
  );
  osf_sync #(.W(1)) i_err_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(werr_i), .q_o(werr_s)
  );

  assign flush_o   = clr_s ^ clr_d_q;
  assign wq_bin    = g2b(wgray_q_i);
  assign empty_o   = (rbin_q == wq_bin);
  assign rd_fire_o = en_i && !flush_o && (orbit_i || run_q);

  always_comb begin
    if (flush_o) rbin_nxt = wq_bin;  // discard leftover words
    else         rbin_nxt = rbin_q + (AW+1)'(rd_fire_o && !empty_o);
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_d_q <= 1'b0;
      rbin_q  <= '0;
      rgray_q <= '0;
      run_q   <= 1'b0;
      rerr_q  <= 1'b0;
      stg_q   <= '0;
      out_q   <= '0;
    end else begin
      clr_d_q <= clr_s;
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      if (!en_i || flush_o) run_q <= 1'b0;
      else if (orbit_i)     run_q <= 1'b1;
      if (rd_fire_o && empty_o) rerr_q <= 1'b1;
      stg_q <= (rd_fire_o && !empty_o) ? rdata_i : '0;
      out_q <= en_i ? stg_q : '0;
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign data_o  = out_q;
  assign err_o   = en_i && (rerr_q || werr_s);
endmodule

// File: rtl/orbit_sync_fifo.sv
module orbit_sync_fifo
  import orbit_sync_pkg::*;
#(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned ORBIT_LEN = 3564,
  parameter int unsigned DLY_W     = 6
) (
  input  logic                         wclk_i,
  input  logic                         rclk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         wr_orbit_i,
  input  logic [DLY_W-1:0]             delay_i,
  input  logic [$clog2(ORBIT_LEN)-1:0] gap_i,
  input  logic [WORD_W-1:0]            data_i,
  output logic                         full_o,
  input  logic                         rd_orbit_i,
  output logic [WORD_W-1:0]            data_o,
  output logic                         empty_o,
  output logic                         err_o
);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(ORBIT_LEN);

  logic          wr_we, wr_req, wr_err, wr_tgl;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [AW:0]   wr_gray, wr_bin, wr_level, rd_gray, rd_gray_w, wr_gray_r;
  logic          rd_fire, rd_flush;
  word_t         rd_data;

  osf_sync #(.W(AW+1)) i_rptr_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rd_gray), .q_o(rd_gray_w)
  );
  osf_sync #(.W(AW+1)) i_wptr_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wr_gray_r)
  );

  osf_wr_ctrl #(
    .AW(AW), .CNT_W(CNT_W), .DLY_W(DLY_W), .ORBIT_LEN(ORBIT_LEN)
  ) i_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .en_i(en_i), .orbit_i(wr_orbit_i),
    .delay_i(delay_i), .gap_i(gap_i), .rgray_q_i(rd_gray_w),
    .we_o(wr_we), .waddr_o(wr_addr), .wgray_o(wr_gray), .wbin_o(wr_bin),
    .level_o(wr_level), .wr_req_o(wr_req), .full_o(full_o),
    .err_o(wr_err), .clr_tgl_o(wr_tgl)
  );

  osf_mem #(.AW(AW)) i_mem (
    .wclk_i(wclk_i), .we_i(wr_we), .waddr_i(wr_addr), .wdata_i(data_i),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  osf_rd_ctrl #(.AW(AW)) i_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .en_i(en_i), .orbit_i(rd_orbit_i),
    .wgray_q_i(wr_gray_r), .clr_tgl_i(wr_tgl), .werr_i(wr_err),
    .rdata_i(rd_data), .raddr_o(rd_addr), .rgray_o(rd_gray),
    .empty_o(empty_o), .data_o(data_o), .err_o(err_o),
    .rd_fire_o(rd_fire), .flush_o(rd_flush)
  );
endmodule

// File: rtl/osf_checker.sv
module osf_checker #(
  parameter int unsigned AW    = 7,
  parameter int unsigned DEPTH = 128
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        full_i,
  input logic        empty_i,
  input logic        err_i,
  input logic [8:0]  data_i,
  input logic [AW:0] level_i,
  input logic [AW:0] wbin_i,
  input logic        wr_req_i,
  input logic        rd_fire_i,
  input logic        flush_i
);
  a_r7_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    level_i <= (AW+1)'(DEPTH));

  a_r7_full_holds_ptr: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_i && wr_req_i) |=> $stable(wbin_i));

  a_r5_flush_empties: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    flush_i |=> empty_i);

  a_r9_empty_read_zero: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_fire_i && empty_i) |=> ##1 (data_i == 9'd0));

  a_r9_err_sticky: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (err_i && en_i) |=> (err_i || !en_i));

  a_r10_disabled_quiet: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !en_i |=> (data_i == 9'd0 && !err_i));
endmodule

bind orbit_sync_fifo osf_checker #(.AW(AW), .DEPTH(DEPTH)) i_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .en_i(en_i),
  .full_i(full_o), .empty_i(empty_o), .err_i(err_o), .data_i(data_o),
  .level_i(wr_level), .wbin_i(wr_bin), .wr_req_i(wr_req),
  .rd_fire_i(rd_fire), .flush_i(rd_flush)
);

// File: tb/test_orbit_sync_fifo.sv
module test_orbit_sync_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;

  logic        wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0, en = 1'b1;
  logic        worbit = 1'b0, rorbit = 1'b0;
  logic [5:0]  delay = '0;
  logic [11:0] gap = 12'd1;
  logic [8:0]  din = '0;
  logic        full, empty, err;
  logic [8:0]  dout;

  int n_tests = 0, n_fail = 0;
  logic [8:0] hist [65536];
  int cyc = 0, cm = 0;
  bit wreq = 1'b0;

  orbit_sync_fifo i_orbit_sync_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .en_i(en),
    .wr_orbit_i(worbit), .delay_i(delay), .gap_i(gap), .data_i(din),
    .full_o(full), .rd_orbit_i(rorbit), .data_o(dout),
    .empty_o(empty), .err_o(err)
  );

  always #(CLK_PERIOD/2) wclk = ~wclk;
  initial begin
    #3;
    forever #(CLK_PERIOD/2) rclk = ~rclk;
  end

  // write-side driver: one random word per crossing
  initial begin
    void'($urandom(32'h0cab_1e57));
    forever begin
      @(negedge wclk);
      din = 9'($urandom);
      hist[cyc % 65536] = din;
      if (wreq) begin
        worbit = 1'b1;
        cm     = cyc;
        wreq   = 1'b0;
      end else begin
        worbit = 1'b0;
      end
      cyc++;
    end
  end

  function automatic logic [8:0] exp_word(int idx);
    return hist[idx % 65536];
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rwait(int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic do_reset(bit en_v);
    en = en_v;
    rst_ni = 1'b0;
    rwait(4);
    rst_ni = 1'b1;
    rwait(2);
  endtask

  task automatic fire_wr();
    wreq = 1'b1;
    wait (!wreq);
  endtask

  task automatic rd_pulse();
    @(negedge rclk) rorbit = 1'b1;
    @(negedge rclk) rorbit = 1'b0;
  endtask

  task automatic run_orbit(int d, int off, int gap_v, int idx);
    int e, n;
    string tag;
    delay = 6'(d);
    gap   = 12'(gap_v);
    fire_wr();
    e = cm + d;
    n = gap_v - off - 8;
    rwait(d + off);
    rd_pulse();
    for (int k = 0; k < n; k++) begin
      @(negedge rclk);
      if (k == 0) tag = (idx == 0) ? "R4" : "R6";
      else        tag = (d == 0) ? "R2" : "R3";
      check(dout == exp_word(e + k), tag, dout, exp_word(e + k));
    end
    rwait(gap_v + 20);
    check(dout == 9'd0, "R5", dout, 0);
    check(empty == 1'b1, "R5", empty, 1);
    check(err == 1'b0, "R11", err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog: actual running expected done");
    summary();
  end

  initial begin
    do_reset(1'b1);
    check(dout == 9'd0, "R1", dout, 0);
    check(err == 1'b0, "R1", err, 0);
    check(empty == 1'b1, "R1", empty, 1);
    check(full == 1'b0, "R1", full, 0);

    // directed orbit with zero delay, then random orbits without reset
    run_orbit(0, 12, 60, 0);
    for (int i = 1; i < 6; i++) begin
      int d, off, g;
      d   = 1 + int'($urandom % 15);
      off = 8 + int'($urandom % 33);
      g   = off + 30 + int'($urandom % 70);
      run_orbit(d, off, g, i);
    end

    // underflow: read marker with nothing written
    do_reset(1'b1);
    rd_pulse();
    @(negedge rclk);
    check(dout == 9'd0, "R9", dout, 0);
    check(err == 1'b1, "R9", err, 1);
    rwait(5);
    check(err == 1'b1, "R9", err, 1);

    // overflow: write past depth with no reads
    do_reset(1'b1);
    delay = '0;
    gap   = 12'd300;
    fire_wr();
    begin
      int e0;
      e0 = cm;
      rwait(150);
      check(full == 1'b1, "R7", full, 1);
      check(err == 1'b1, "R8", err, 1);
      rd_pulse();
      for (int k = 0; k < DEPTH; k++) begin
        @(negedge rclk);
        check(dout == exp_word(e0 + k), "R7", dout, exp_word(e0 + k));
      end
      rwait(10);
      check(err == 1'b1, "R8", err, 1);
    end

    // disabled channel
    do_reset(1'b0);
    delay = '0;
    gap   = 12'd40;
    fire_wr();
    rwait(10);
    rd_pulse();
    for (int k = 0; k < 20; k++) begin
      @(negedge rclk);
      check(dout == 9'd0 && err == 1'b0, "R10", {dout, err}, 0);
    end
    check(empty == 1'b1, "R10", empty, 1);
    check(full == 1'b0, "R10", full, 0);

    summary();
  end
endmodule